// File: doc/BRIEF.md
# EEPROM Write-Protection Sequence Controller

This block sits on the byte-write path of a nonvolatile memory made of several equal blocks. Each block owns a protection flag. Every write on the incoming bus is sorted into one of three kinds: a step of a command code, a data byte that opens or fills a page, or an ordinary write. The controller then decides whether the data reaches the array. A register array stands in for the storage cells, and a cycle counter stands in for the programming time. While that counter runs, `busy` is high.

Two codes are recognised. The arming code is three writes: 0xAA to offset 0x5555, 0x55 to offset 0x2AAA, then 0xA0 to offset 0x5555. The release code is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x20@0x5555. Either code opens a page window of up to `PAGE_MAX` data bytes at any addresses. The window closes when the page fills or after `IDLE_TO` quiet cycles. A write cycle of `TWC` clock cycles follows. At its end the queued bytes are stored and the flag of the coded block changes. A write to a protected block that comes without a code still costs a full write cycle, but nothing is stored.

The write bus is a valid/ready stream. `wr_ready` is low for the whole write cycle, and a beat is taken only in a cycle where `wr_valid` and `wr_ready` are both high. A source that drops `wr_valid` before `wr_ready` returns has offered nothing. The flags are cleared only by the power-up input `por_n`. `rst_n` leaves both the flags and the array untouched.

Top module: `eeprom_wp_guard`

## Requirements
- R1: With `por_n` low, every protection flag is cleared. After `rst_n` is released, `busy` is 0 and `wr_ready` is 1.
- R2: An ordinary write to an unprotected block drives `busy` high for exactly `TWC` cycles, starting the cycle after the beat is taken. When `busy` falls, the byte is stored at the in-block index given by the low `IDX_W` address bits.
- R3: An ordinary write to a protected block also drives `busy` high for exactly `TWC` cycles, but it leaves every array location unchanged.
- R4: The arming code (0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, all in the same block) sets that block's flag when its write cycle ends, even if no data byte follows.
- R5: The release code (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555, all in the same block) clears that block's flag when its write cycle ends, even if no data byte follows.
- R6: After a code, data bytes are queued and stored in arrival order when the cycle ends. The write cycle begins after `IDLE_TO` cycles with no taken beat, counted from the last taken beat or from the final code write.
- R7: Taking the `PAGE_MAX`-th byte of a window starts the write cycle on the next cycle, without waiting for the idle timeout.
- R8: The flags are independent per block. A window byte aimed at another block is stored only if that block is unprotected.
- R9: Pulsing `rst_n` alone changes neither the flags nor the array contents.
- R10: A write that does not match the next expected step of a code, or that targets a different block than the code began in, cancels the code. That write is then handled as an ordinary write under the current flags.
- R11: A beat offered while `wr_ready` is low is not taken. It starts no write cycle and stores nothing.
- R12: The block number is the address bits above bit 16. Code offsets are matched on all 17 low bits. Writes consumed as code steps are never written into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of sequencing state |
| por_n | input | 1 | Synchronous active-low power-up clear of the protection flags |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Controller can take a beat (low during a write cycle) |
| wr_addr | input | BLK_W+17 | Block number above bit 16, in-block offset in bits 16..0 |
| wr_data | input | 8 | Write byte |
| busy | output | 1 | Write cycle in progress |
| prot_flags | output | NUM_BLK | One protection flag per block |
| rd_addr | input | BLK_W+IDX_W | Read index: block number then in-block index |
| rd_data | output | 8 | Array byte at `rd_addr` |

## Verification
The bench first fills the whole array with ordinary writes while both blocks are unprotected. This confirms address decoding, and it gives every later sweep a known reference. It then repeats arming windows with every byte count from zero to a full page. The zero-byte window and the idle-timeout windows are told apart from the full page by the quiet gap before `busy`. Window bytes are aimed at the block's own locations and at a foreign block in both protection states, which exercises the per-block rule. Broken codes (a wrong value, and a right value in the wrong block) and beats held during `busy` show that stray traffic stores only what the ordinary-write rules allow. After each pattern, every array byte and both flags are compared with an arithmetic model.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned OFF_W = 17;
  localparam logic [OFF_W-1:0] LOC_HI = 17'h05555;
  localparam logic [OFF_W-1:0] LOC_LO = 17'h02AAA;
  localparam logic [7:0] KEY_OPEN  = 8'hAA;
  localparam logic [7:0] KEY_TWO   = 8'h55;
  localparam logic [7:0] KEY_ARM   = 8'hA0;
  localparam logic [7:0] KEY_LONG  = 8'h80;
  localparam logic [7:0] KEY_FREE  = 8'h20;

  typedef enum logic [2:0] {
    SQ_REST, SQ_K1, SQ_K2, SQ_K3, SQ_K4, SQ_K5
  } seq_stage_e;

  typedef enum logic [1:0] {
    WK_PLAIN, WK_STEP, WK_ARM, WK_FREE
  } wr_kind_e;

  typedef enum logic [1:0] {
    CT_IDLE, CT_WIN, CT_CYC
  } ctl_state_e;

  typedef enum logic [1:0] {
    FA_NONE, FA_SET, FA_CLR
  } flag_act_e;
endpackage

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
  import wp_pkg::*;
#(
  parameter int unsigned BLK_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [OFF_W-1:0] off,
  input  logic [BLK_W-1:0] blk,
  input  logic [7:0]       data,
  output wr_kind_e         kind
);
  seq_stage_e       stage_q, stage_d;
  logic [BLK_W-1:0] sblk_q;
  logic             same_blk, at_hi, at_lo;

  always_comb begin
    same_blk = (stage_q == SQ_REST) || (blk == sblk_q);
    at_hi    = same_blk && (off == LOC_HI);
    at_lo    = same_blk && (off == LOC_LO);
    kind     = WK_PLAIN;
    stage_d  = SQ_REST;
    unique case (stage_q)
      SQ_REST: if (at_hi && data == KEY_OPEN) begin
        kind = WK_STEP; stage_d = SQ_K1;
      end
      SQ_K1: if (at_lo && data == KEY_TWO) begin
        kind = WK_STEP; stage_d = SQ_K2;
      end
      SQ_K2: begin
        if (at_hi && data == KEY_ARM) begin
          kind = WK_ARM;
        end else if (at_hi && data == KEY_LONG) begin
          kind = WK_STEP; stage_d = SQ_K3;
        end
      end
      SQ_K3: if (at_hi && data == KEY_OPEN) begin
        kind = WK_STEP; stage_d = SQ_K4;
      end
      SQ_K4: if (at_lo && data == KEY_TWO) begin
        kind = WK_STEP; stage_d = SQ_K5;
      end
      SQ_K5: if (at_hi && data == KEY_FREE) begin
        kind = WK_FREE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= SQ_REST;
      sblk_q  <= '0;
    end else if (step) begin
      stage_q <= stage_d;
      if (stage_q == SQ_REST) sblk_q <= blk;
    end
  end

  a_r10_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(stage_q));
  a_r10_break_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == WK_PLAIN) |=> stage_q == SQ_REST);
endmodule

// File: rtl/wp_page_buf.sv
module wp_page_buf #(
  parameter int unsigned PAGE_MAX = 128,
  parameter int unsigned ENT_W    = 16,
  localparam int unsigned CNT_W   = $clog2(PAGE_MAX + 1),
  localparam int unsigned SEL_W   = (PAGE_MAX > 1) ? $clog2(PAGE_MAX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [ENT_W-1:0] push_ent,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ENT_W-1:0] rd_ent,
  output logic [CNT_W-1:0] count,
  output logic             full_next
);
  logic [ENT_W-1:0] slot_q [PAGE_MAX];
  logic [CNT_W-1:0] count_q;

  for (genvar g = 0; g < PAGE_MAX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !clear && count_q == CNT_W'(g)) slot_q[g] <= push_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count_q <= '0;
    else if (push && count_q < CNT_W'(PAGE_MAX)) count_q <= count_q + 1'b1;
  end

  assign rd_ent    = slot_q[rd_sel];
  assign count     = count_q;
  assign full_next = (count_q == CNT_W'(PAGE_MAX - 1));

  a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(PAGE_MAX));
  a_r6_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear && count_q < CNT_W'(PAGE_MAX)) |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer
  import wp_pkg::*;
#(
  parameter int unsigned TWC     = 160,
  parameter int unsigned IDLE_TO = 32,
  localparam int unsigned TW     = (TWC > 1) ? $clog2(TWC) : 1,
  localparam int unsigned IW     = (IDLE_TO > 1) ? $clog2(IDLE_TO) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          open_win,
  input  logic          start_now,
  output ctl_state_e    state,
  output logic          busy,
  output logic          done,
  output logic [TW-1:0] cyc_idx
);
  ctl_state_e    st_q;
  logic [IW-1:0] idle_q;
  logic [TW-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CT_IDLE;
      idle_q <= '0;
      cyc_q  <= '0;
    end else begin
      unique case (st_q)
        CT_IDLE: begin
          if (open_win) begin
            st_q <= CT_WIN; idle_q <= '0;
          end else if (start_now) begin
            st_q <= CT_CYC; cyc_q <= '0;
          end
        end
        CT_WIN: begin
          if (start_now) begin
            st_q <= CT_CYC; cyc_q <= '0;
          end else if (take) begin
            idle_q <= '0;
          end else if (idle_q == IW'(IDLE_TO - 1)) begin
            st_q <= CT_CYC; cyc_q <= '0;
          end else begin
            idle_q <= idle_q + 1'b1;
          end
        end
        CT_CYC: begin
          if (cyc_q == TW'(TWC - 1)) st_q <= CT_IDLE;
          else cyc_q <= cyc_q + 1'b1;
        end
        default: st_q <= CT_IDLE;
      endcase
    end
  end

  assign state   = st_q;
  assign busy    = (st_q == CT_CYC);
  assign done    = busy && (cyc_q == TW'(TWC - 1));
  assign cyc_idx = cyc_q;

  a_r2_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r2_cycle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  a_r6_idle_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CT_WIN && !take && !start_now && idle_q == IW'(IDLE_TO - 1)) |=> busy);
  a_r6_take_keeps_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CT_WIN && take && !start_now) |=> (st_q == CT_WIN && idle_q == '0));
endmodule

// File: rtl/eeprom_wp_guard.sv
module eeprom_wp_guard
  import wp_pkg::*;
#(
  parameter int unsigned NUM_BLK  = 2,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned PAGE_MAX = 128,
  parameter int unsigned TWC      = 160,
  parameter int unsigned IDLE_TO  = 32,
  localparam int unsigned BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
  localparam int unsigned AW      = BLK_W + OFF_W,
  localparam int unsigned MW      = BLK_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  output logic               busy,
  output logic [NUM_BLK-1:0] prot_flags,
  input  logic [MW-1:0]      rd_addr,
  output logic [7:0]         rd_data
);
  localparam int unsigned CNT_W = $clog2(PAGE_MAX + 1);
  localparam int unsigned SEL_W = (PAGE_MAX > 1) ? $clog2(PAGE_MAX) : 1;
  localparam int unsigned TW    = (TWC > 1) ? $clog2(TWC) : 1;
  localparam int unsigned ENT_W = MW + 8 + 1;
  localparam int unsigned DEPTH = NUM_BLK << IDX_W;

  ctl_state_e          st;
  wr_kind_e            kind;
  flag_act_e           win_act_q;
  logic                take, busy_i, done, done_eff;
  logic                open_win, plain_go, fill, start_now;
  logic                push, push_ok, full_next, drain_live;
  logic [BLK_W-1:0]    w_blk, win_blk_q, e_blk;
  logic [OFF_W-1:0]    w_off;
  logic [IDX_W-1:0]    w_idx, e_idx;
  logic [7:0]          e_data;
  logic                e_ok;
  logic [CNT_W-1:0]    buf_cnt;
  logic [TW-1:0]       cyc_idx;
  logic [ENT_W-1:0]    ent;
  logic [NUM_BLK-1:0]  prot_q;
  logic [7:0]          mem_q [DEPTH];

  assign w_blk    = wr_addr[AW-1:OFF_W];
  assign w_off    = wr_addr[OFF_W-1:0];
  assign w_idx    = wr_addr[IDX_W-1:0];
  assign wr_ready = !busy_i;
  assign take     = wr_valid && wr_ready;

  wp_seq_detect #(.BLK_W(BLK_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take && st == CT_IDLE),
    .off   (w_off),
    .blk   (w_blk),
    .data  (wr_data),
    .kind  (kind)
  );

  always_comb begin
    open_win  = take && st == CT_IDLE && (kind == WK_ARM || kind == WK_FREE);
    plain_go  = take && st == CT_IDLE && kind == WK_PLAIN;
    fill      = take && st == CT_WIN && full_next;
    start_now = plain_go || fill;
    push_ok   = (st == CT_WIN) ? ((w_blk == win_blk_q) || !prot_q[w_blk]) : 1'b1;
    push      = (plain_go && !prot_q[w_blk]) || (take && st == CT_WIN);
  end

  wp_cycle_timer #(.TWC(TWC), .IDLE_TO(IDLE_TO)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .open_win  (open_win),
    .start_now (start_now),
    .state     (st),
    .busy      (busy_i),
    .done      (done),
    .cyc_idx   (cyc_idx)
  );

  assign done_eff = done && rst_n;

  wp_page_buf #(.PAGE_MAX(PAGE_MAX), .ENT_W(ENT_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (done_eff),
    .push      (push),
    .push_ent  ({w_blk, w_idx, wr_data, push_ok}),
    .rd_sel    (cyc_idx[SEL_W-1:0]),
    .rd_ent    (ent),
    .count     (buf_cnt),
    .full_next (full_next)
  );

  assign {e_blk, e_idx, e_data, e_ok} = ent;
  assign drain_live = busy_i && (32'(cyc_idx) < 32'(buf_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_act_q <= FA_NONE;
      win_blk_q <= '0;
    end else if (open_win) begin
      win_act_q <= (kind == WK_ARM) ? FA_SET : FA_CLR;
      win_blk_q <= w_blk;
    end else if (done) begin
      win_act_q <= FA_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) prot_q <= '0;
    else if (done_eff && win_act_q == FA_SET) prot_q[win_blk_q] <= 1'b1;
    else if (done_eff && win_act_q == FA_CLR) prot_q[win_blk_q] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (drain_live && e_ok) mem_q[{e_blk, e_idx}] <= e_data;
  end

  assign busy       = busy_i;
  assign prot_flags = prot_q;
  assign rd_data    = mem_q[rd_addr];

  a_r4_flags_only_at_end: assert property (@(posedge clk) disable iff (!por_n)
    !(done_eff && win_act_q != FA_NONE) |=> $stable(prot_q));
  a_r3_locked_queues_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_go && prot_q[w_blk]) |=> buf_cnt == '0);
  a_r11_busy_takes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !done) |=> $stable(buf_cnt));
  a_r7_full_page_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> busy_i);
endmodule

// File: tb/eeprom_wp_guard_tb.sv
module eeprom_wp_guard_tb;
  localparam int CLK_P = 10;
  localparam int NB    = 2;
  localparam int IW    = 6;
  localparam int PM    = 8;
  localparam int TWC_C = 12;
  localparam int ITO   = 5;
  localparam int BW    = 1;
  localparam int AW    = BW + 17;
  localparam int MW    = BW + IW;
  localparam int NIDX  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          por_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [MW-1:0] rd_addr = '0;
  logic          wr_ready, busy;
  logic [NB-1:0] prot_flags;
  logic [7:0]    rd_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]    mdl [NB][NIDX];
  logic [NB-1:0] mprot = '0;

  always #(CLK_P/2) clk = ~clk;

  eeprom_wp_guard #(.NUM_BLK(NB), .IDX_W(IW), .PAGE_MAX(PM), .TWC(TWC_C), .IDLE_TO(ITO)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .prot_flags(prot_flags),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int blk, input logic [16:0] off, input logic [7:0] d);
    @(negedge clk);
    check("R11 ready before beat", 32'(wr_ready), 32'd1);
    wr_valid = 1'b1;
    wr_addr  = {BW'(blk), off};
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_cycle(input string req, input int exp_gap);
    int gap = 0;
    int len = 0;
    while (!busy && gap < 1000) begin gap++; @(negedge clk); end
    while (busy && len < 1000) begin len++; @(negedge clk); end
    check({req, " quiet gap"}, 32'(gap), 32'(exp_gap));
    check({req, " busy length"}, 32'(len), 32'(TWC_C));
  endtask

  task automatic sweep(input string req);
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < NIDX; i++) begin
        rd_addr = MW'((b << IW) | i);
        #1;
        check({req, " array byte"}, 32'(rd_data), 32'(mdl[b][i]));
      end
    end
    check({req, " flags"}, 32'(prot_flags), 32'(mprot));
  endtask

  task automatic plain(input int b, input int i, input logic [7:0] d, input string req);
    put(b, 17'(i), d);
    if (!mprot[b]) mdl[b][i] = d;
    finish_cycle(req, 0);
  endtask

  task automatic page(input int b, input bit arm, input int n, input int seed,
                      input int tgt, input string req);
    put(b, 17'h05555, 8'hAA);
    put(b, 17'h02AAA, 8'h55);
    if (arm) begin
      put(b, 17'h05555, 8'hA0);
    end else begin
      put(b, 17'h05555, 8'h80);
      put(b, 17'h05555, 8'hAA);
      put(b, 17'h02AAA, 8'h55);
      put(b, 17'h05555, 8'h20);
    end
    for (int k = 0; k < n; k++) begin
      int ix;
      logic [7:0] d;
      ix = (seed * 7 + k * 5) % NIDX;
      d  = 8'(seed * 31 + k * 13 + 1);
      put(tgt, 17'(ix), d);
      if (tgt == b || !mprot[tgt]) mdl[tgt][ix] = d;
    end
    finish_cycle(req, (n == PM) ? 0 : ITO);
    mprot[b] = arm;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 ready after reset", 32'(wr_ready), 32'd1);
    check("R1 flags at power-up", 32'(prot_flags), 32'd0);

    // R2: fill every location of both blocks while unprotected
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < NIDX; i++)
        plain(b, i, 8'((b * NIDX + i) ^ 8'h5A), "R2");
    sweep("R2");

    // R4: arming with no data byte still sets the flag
    page(0, 1'b1, 0, 1, 0, "R4");
    sweep("R4");

    // R3: protected block keeps its data; R8: other block still writable
    plain(0, 10, 8'hE1, "R3");
    sweep("R3");
    plain(1, 10, 8'hE2, "R8");
    sweep("R8");

    // R6 / R7: every page length from 1 to a full page
    for (int n = 1; n <= PM; n++) begin
      page(0, 1'b1, n, n + 2, 0, (n == PM) ? "R7" : "R6");
      sweep("R6");
    end

    // R8: foreign bytes to an unprotected block land, to a protected one they drop
    page(0, 1'b1, 3, 40, 1, "R8");
    sweep("R8");
    page(1, 1'b1, 0, 3, 1, "R8");
    page(1, 1'b1, 3, 41, 0, "R8");
    sweep("R8");

    // R5: release with no data byte
    page(1, 1'b0, 0, 5, 1, "R5");
    sweep("R5");

    // R10: wrong value breaks the code, write handled under protection
    put(0, 17'h05555, 8'hAA);
    put(0, 17'(3), 8'h12);
    finish_cycle("R10", 0);
    put(1, 17'h05555, 8'hAA);
    put(1, 17'h02AAA, 8'h55);
    put(1, 17'(9), 8'h33);
    mdl[1][9] = 8'h33;
    finish_cycle("R10", 0);
    sweep("R10");

    // R12: code started in block 0, second step in block 1 is an ordinary write
    put(0, 17'h05555, 8'hAA);
    put(1, 17'h02AAA, 8'h55);
    mdl[1][17'h02AAA % NIDX] = 8'h55;
    finish_cycle("R12", 0);
    sweep("R12");

    // R5: release with data bytes
    page(0, 1'b0, 4, 50, 0, "R5");
    sweep("R5");

    // R11: a beat held during busy and withdrawn is never taken
    put(1, 17'(5), 8'h44);
    mdl[1][5] = 8'h44;
    wr_valid = 1'b1;
    wr_addr  = {BW'(1), 17'(6)};
    wr_data  = 8'h99;
    repeat (TWC_C - 2) @(negedge clk);
    wr_valid = 1'b0;
    while (busy) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check("R11 no cycle from withdrawn beat", 32'(busy), 32'd0);
      @(negedge clk);
    end
    sweep("R11");

    // R9: reset keeps flags and array
    page(1, 1'b1, 0, 7, 1, "R4");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 busy after reset", 32'(busy), 32'd0);
    sweep("R9");

    // R1: power-up clear
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R1 flags after power-up clear", 32'(prot_flags), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule